// File: doc/BRIEF.md
# Bus Master Performance Event Counters

This block watches the masters on an internal shared bus and counts performance events for them. Every agent has three lines into the monitor: a request line, an ownership line (at most one agent is the bus master in any cycle) and a transaction-start strobe. From these lines the block forms three event kinds for each agent. Acquisition latency counts the cycles in which the agent is waiting for the bus. Ownership duration counts the cycles in which the agent is the master. Grant occurrences counts each new transaction once, however many cycles it lasts.

A control register selects the monitoring mode. The mode decides which agent and which event kind each of the eight counters follows. One mode covers three DMA channels and an accelerator agent. Another covers the bus as a whole, two address translation units and the core interface. Software reads the counters, the overflow flags and the control register through a small register port, and can clear any chosen set of counters. All counting runs on the bus clock.

Top module: `bus_perf_monitor`

## Requirements
- R1: An ownership-duration counter advances by one in every enabled cycle in which its agent's ownership line is high.
- R2: A grant counter advances once per transaction. It counts the first cycle in which the agent owns the bus after a cycle without ownership, and it counts any owned cycle in which the agent's transaction-start strobe is high, so back-to-back transactions each count. A cycle with both conditions counts once.
- R3: An acquisition counter advances in every enabled cycle in which the agent's request is high and its ownership line is low, whether the bus is idle or another master holds it.
- R4: Mode 1 (control bits [1:0] = 1): counter k (k = 0..3) counts ownership of agent k, and counter 4+k counts grants of agent k. Agents 0, 1 and 2 are DMA channels and agent 3 is the accelerator.
- R5: Mode 2: counter 0 counts cycles in which any agent owns the bus. Counters 1, 2 and 3 count ownership of agents 4, 5 and 6 (primary translation, secondary translation, core interface). Counters 4, 5 and 6 count acquisition cycles of the same three agents. Counter 7 counts grants of agent 6.
- R6: In modes 0 and 3 no counter advances.
- R7: When the enable bit (control bit 2) is low, every counter holds its value.
- R8: A write to the control register (address 0) whose mode field differs from the current mode clears all counters and all overflow flags in that cycle. A write that keeps the same mode clears nothing. Control changes take effect from the next cycle.
- R9: With the saturate bit (control bit 3) low, a counter at its maximum wraps to zero on its next event, and its sticky overflow flag (bit i of address 1 for counter i) is set.
- R10: With the saturate bit high, a counter at its maximum stays at its maximum on further events, and its overflow flag is set.
- R11: A read (reg_re high) returns the addressed value combinationally in the same cycle: counter i at address 8+i, overflow flags at address 1, control at address 0. Other addresses, and any cycle with reg_re low, return zero. Reading has no effect on any count.
- R12: Writing a mask to address 2 clears each counter whose bit is set, together with that counter's overflow flag. Clearing takes priority over an event in the same cycle.
- R13: Writing ones to address 1 clears those overflow flags. An overflow raised in the same cycle takes priority over the write.
- R14: After a synchronous active-low reset, all counters, overflow flags and the control register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| agt_own | input | 7 | Per-agent ownership, at most one bit high |
| agt_req | input | 7 | Per-agent bus request |
| agt_tstart | input | 7 | Per-agent transaction-start strobe |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | CNT_W | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | CNT_W | Read data, valid in the same cycle as reg_re |

## Verification
The embedded assertions check the following on every cycle: a counter holds whenever it is neither incremented nor cleared; it wraps or saturates at its maximum as the control bit selects; an overflow flag stays set until it is cleared; a mode change empties every counter; the idle modes leave counters untouched; and a rising ownership always produces a grant event. Whether each counter follows the right agent and event kind in each mode, how strobed back-to-back transactions are counted, and how same-cycle clears, writes and overflows interact can only be shown by the bench. The bench does this by comparing every readable register against a cycle-level model after directed sequences and random bus traffic.

// File: rtl/bpm_pkg.sv
`timescale 1ns/1ps
// Package for the bus performance monitor. Holds the agent numbering, the
// counter count, the register map and the control register layout.
// Assumes eight counters and seven monitored agents.
package bpm_pkg;
    localparam int NUM_AGT   = 7;
    localparam int NUM_CNT   = 8;
    localparam int CNT_IDX_W = $clog2(NUM_CNT);
    localparam int REG_AW    = CNT_IDX_W + 1;

    // agent positions on the per-agent vectors
    localparam int AG_DMA0 = 0;
    localparam int AG_DMA1 = 1;
    localparam int AG_DMA2 = 2;
    localparam int AG_ACC  = 3;
    localparam int AG_PXL  = 4;
    localparam int AG_SXL  = 5;
    localparam int AG_CORE = 6;

    // register addresses below the counter window (counters at NUM_CNT + i)
    localparam logic [REG_AW-1:0] ADDR_CTRL = REG_AW'(0);
    localparam logic [REG_AW-1:0] ADDR_OVF  = REG_AW'(1);
    localparam logic [REG_AW-1:0] ADDR_CLR  = REG_AW'(2);

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_DMA = 2'd1,
        MODE_XLT = 2'd2,
        MODE_RSV = 2'd3
    } mon_mode_t;

    typedef struct packed {
        logic      sat;
        logic      en;
        mon_mode_t mode;
    } mon_ctrl_t;
endpackage

// File: rtl/bpm_event_detect.sv
`timescale 1ns/1ps
// Per-agent event detection. Turns the request, ownership and
// transaction-start lines into ownership, grant and acquisition events.
// Assumes the ownership vector is one-hot or zero.
module bpm_event_detect
    import bpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_AGT-1:0] own,
    input  logic [NUM_AGT-1:0] req,
    input  logic [NUM_AGT-1:0] tstart,
    output logic [NUM_AGT-1:0] own_ev,
    output logic [NUM_AGT-1:0] gnt_ev,
    output logic [NUM_AGT-1:0] acq_ev
);
    logic [NUM_AGT-1:0] own_q;

    // remember last cycle's ownership so a new tenure can be recognised
    always_ff @(posedge clk) begin
        if (!rst_n) own_q <= '0;
        else        own_q <= own;
    end

    for (genvar i = 0; i < NUM_AGT; i++) begin : g_agt
        assign own_ev[i] = own[i];
        assign gnt_ev[i] = own[i] & (~own_q[i] | tstart[i]);
        assign acq_ev[i] = req[i] & ~own[i];

        // R2: a fresh tenure always yields a grant event
        a_r2_new_tenure: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(own[i]) |-> gnt_ev[i]);
        // R2: continuing tenure without a strobe yields no grant event
        a_r2_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
            (own[i] && $past(own[i]) && !tstart[i]) |-> !gnt_ev[i]);
    end
endmodule

// File: rtl/bpm_event_route.sv
`timescale 1ns/1ps
// Mode-dependent routing of agent events onto the counter inputs.
// Purely combinational; modes OFF and RSV route nothing.
module bpm_event_route
    import bpm_pkg::*;
(
    input  mon_mode_t          mode,
    input  logic [NUM_AGT-1:0] own_ev,
    input  logic [NUM_AGT-1:0] gnt_ev,
    input  logic [NUM_AGT-1:0] acq_ev,
    output logic [NUM_CNT-1:0] hit
);
    // pick each counter's event source for the active mode
    always_comb begin
        hit = '0;
        unique case (mode)
            MODE_DMA: begin
                hit[0] = own_ev[AG_DMA0];
                hit[1] = own_ev[AG_DMA1];
                hit[2] = own_ev[AG_DMA2];
                hit[3] = own_ev[AG_ACC];
                hit[4] = gnt_ev[AG_DMA0];
                hit[5] = gnt_ev[AG_DMA1];
                hit[6] = gnt_ev[AG_DMA2];
                hit[7] = gnt_ev[AG_ACC];
            end
            MODE_XLT: begin
                hit[0] = |own_ev;
                hit[1] = own_ev[AG_PXL];
                hit[2] = own_ev[AG_SXL];
                hit[3] = own_ev[AG_CORE];
                hit[4] = acq_ev[AG_PXL];
                hit[5] = acq_ev[AG_SXL];
                hit[6] = acq_ev[AG_CORE];
                hit[7] = gnt_ev[AG_CORE];
            end
            default: hit = '0;
        endcase
    end
endmodule

// File: rtl/bpm_counter.sv
`timescale 1ns/1ps
// One event counter with clear, wrap-or-saturate at the top and an
// overflow pulse. Clear takes priority over an increment.
module bpm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             sat,
    output logic [CNT_W-1:0] count,
    output logic             ovf_set
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;
    assign at_max  = (count == CNT_MAX);
    assign ovf_set = inc & ~clr & at_max;

    // count events; clear first, then wrap or hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (inc) begin
            if (at_max)  count <= sat ? CNT_MAX : '0;
            else         count <= count + 1'b1;
        end
    end

    // R7: no increment and no clear means the value holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));
    // R9: wrap to zero at the top when not saturating
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !sat && count == CNT_MAX) |=> (count == '0));
    // R10: saturating counter stays at the top
    a_r10_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && sat && count == CNT_MAX) |=> (count == CNT_MAX));
    // R12: a clear empties the counter
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/bus_perf_monitor.sv
`timescale 1ns/1ps
// Bus master performance event counters. Holds the control register and the
// overflow flags, decodes register writes, drives eight counters from routed
// agent events and returns register reads combinationally.
// Assumes CNT_W >= NUM_CNT so the overflow flags fit in one read word.
module bus_perf_monitor
    import bpm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_AGT-1:0] agt_own,
    input  logic [NUM_AGT-1:0] agt_req,
    input  logic [NUM_AGT-1:0] agt_tstart,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_waddr,
    input  logic [CNT_W-1:0]   reg_wdata,
    input  logic               reg_re,
    input  logic [REG_AW-1:0]  reg_raddr,
    output logic [CNT_W-1:0]   reg_rdata
);
    mon_ctrl_t          ctrl_q;
    logic [NUM_CNT-1:0] ovf_q;
    logic [NUM_AGT-1:0] own_ev, gnt_ev, acq_ev;
    logic [NUM_CNT-1:0] hit, clr_vec, ovf_set, w1c;
    logic [CNT_W-1:0]   cnt [NUM_CNT];
    logic               wr_ctrl, mode_chg;
    logic               mode_idle;

    assign wr_ctrl   = reg_we && (reg_waddr == ADDR_CTRL);
    assign mode_chg  = wr_ctrl && (reg_wdata[1:0] != ctrl_q.mode);
    assign w1c       = (reg_we && reg_waddr == ADDR_OVF) ? reg_wdata[NUM_CNT-1:0] : '0;
    assign clr_vec   = {NUM_CNT{mode_chg}}
                     | ((reg_we && reg_waddr == ADDR_CLR) ? reg_wdata[NUM_CNT-1:0] : '0);
    assign mode_idle = (ctrl_q.mode == MODE_OFF) || (ctrl_q.mode == MODE_RSV);

    // control register: mode, enable and saturate bits
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= mon_ctrl_t'(reg_wdata[3:0]);
    end

    // sticky overflow flags: clear beats set, set beats write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= ((ovf_q & ~w1c) | ovf_set) & ~clr_vec;
    end

    bpm_event_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .own    (agt_own),
        .req    (agt_req),
        .tstart (agt_tstart),
        .own_ev (own_ev),
        .gnt_ev (gnt_ev),
        .acq_ev (acq_ev)
    );

    bpm_event_route u_route (
        .mode   (ctrl_q.mode),
        .own_ev (own_ev),
        .gnt_ev (gnt_ev),
        .acq_ev (acq_ev),
        .hit    (hit)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        bpm_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr_vec[i]),
            .inc     (ctrl_q.en & hit[i]),
            .sat     (ctrl_q.sat),
            .count   (cnt[i]),
            .ovf_set (ovf_set[i])
        );

        // R8: a mode change leaves every counter at zero
        a_r8_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
            mode_chg |=> (cnt[i] == '0));
        // R6: idle modes never move a counter
        a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_idle && !clr_vec[i]) |=> $stable(cnt[i]));
        // R13: an overflow flag stays set until cleared
        a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[i] && !clr_vec[i] && !w1c[i]) |=> ovf_q[i]);
        // R9: an overflow event raises the flag
        a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_set[i] && !clr_vec[i]) |=> ovf_q[i]);
    end

    // combinational read port, no side effects on any state
    always_comb begin
        reg_rdata = '0;
        if (reg_re) begin
            if (reg_raddr[REG_AW-1]) begin
                reg_rdata = cnt[reg_raddr[CNT_IDX_W-1:0]];
            end else if (reg_raddr == ADDR_CTRL) begin
                reg_rdata[3:0] = ctrl_q;
            end else if (reg_raddr == ADDR_OVF) begin
                reg_rdata[NUM_CNT-1:0] = ovf_q;
            end
        end
    end

    // R8: the mode change also empties the overflow flags
    a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (ovf_q == '0));
    // R11: no read strobe means zero read data
    a_r11_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |-> (reg_rdata == '0));
endmodule

// File: tb/tb_bus_perf_monitor.sv
`timescale 1ns/1ps
module tb_bus_perf_monitor;
    localparam int CW = 8;
    localparam logic [CW-1:0] MAXV = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    agt_own = '0, agt_req = '0, agt_tstart = '0;
    logic          reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]    reg_waddr = '0, reg_raddr = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // expected state
    logic [CW-1:0] e_cnt [8];
    logic [7:0]    e_ovf;
    logic [3:0]    e_ctrl;
    logic [6:0]    e_pown;

    bus_perf_monitor #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .agt_own(agt_own), .agt_req(agt_req), .agt_tstart(agt_tstart),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_re(reg_re), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] route(input logic [1:0] m, input logic [6:0] o,
                                         input logic [6:0] g, input logic [6:0] a);
        logic [7:0] r;
        r = '0;
        if (m == 2'd1) r = {g[3:0], o[3:0]};
        else if (m == 2'd2) r = {g[6], a[6], a[5], a[4], o[6], o[5], o[4], |o};
        return r;
    endfunction

    task automatic compare(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%0h expected=%0h t=%0t", tag, reg_raddr, act, exp, $time);
        end
    endtask

    // read every register back and compare with the model (R11)
    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            reg_re = 1'b1; reg_raddr = 4'(8 + i);
            #0.2;
            compare(tag, reg_rdata, e_cnt[i]);
        end
        reg_raddr = 4'd1; #0.2;
        compare(tag, reg_rdata, CW'(e_ovf));
        reg_raddr = 4'd0; #0.2;
        compare(tag, reg_rdata, CW'(e_ctrl));
        reg_re = 1'b0; #0.2;
        compare({tag, " R11 no strobe"}, reg_rdata, '0);
    endtask

    // one bus cycle with optional register write, model updated alongside
    task automatic cyc(input logic [6:0] o, input logic [6:0] r, input logic [6:0] t,
                       input bit we, input logic [3:0] wa, input logic [CW-1:0] wd);
        logic [6:0] g, a;
        logic [7:0] hit, setv, clrv, w1;
        logic [CW-1:0] nc [8];
        agt_own = o; agt_req = r; agt_tstart = t;
        reg_we = we; reg_waddr = wa; reg_wdata = wd;
        g = o & (~e_pown | t);
        a = r & ~o;
        hit = route(e_ctrl[1:0], o, g, a);
        setv = '0;
        clrv = '0;
        w1 = '0;
        if (we && wa == 4'd0 && wd[1:0] != e_ctrl[1:0]) clrv = 8'hFF;
        if (we && wa == 4'd2) clrv = clrv | wd[7:0];
        if (we && wa == 4'd1) w1 = wd[7:0];
        for (int i = 0; i < 8; i++) begin
            nc[i] = e_cnt[i];
            if (e_ctrl[2] && hit[i]) begin
                if (e_cnt[i] == MAXV) begin
                    setv[i] = 1'b1;
                    nc[i] = e_ctrl[3] ? MAXV : '0;
                end else nc[i] = e_cnt[i] + 1'b1;
            end
            if (clrv[i]) nc[i] = '0;
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) e_cnt[i] = nc[i];
        e_ovf = ((e_ovf & ~w1) | setv) & ~clrv;
        if (we && wa == 4'd0) e_ctrl = wd[3:0];
        e_pown = o;
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc('0, '0, '0, 0, '0, '0);
    endtask

    task automatic wr(input logic [3:0] wa, input logic [CW-1:0] wd);
        cyc('0, '0, '0, 1, wa, wd);
    endtask

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 8; i++) e_cnt[i] = '0;
        e_ovf = '0; e_ctrl = '0; e_pown = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check_all("R14 reset state");

        // mode 1, enabled: DMA1 back-to-back transactions
        wr(4'd0, 8'h05);
        cyc(7'b0000010, 7'b0000010, 7'b0000010, 0, '0, '0);
        cyc(7'b0000010, 7'b0000000, 7'b0000000, 0, '0, '0);
        cyc(7'b0000010, 7'b0000000, 7'b0000010, 0, '0, '0);
        cyc(7'b0001000, 7'b0000000, 7'b0000000, 0, '0, '0);
        cyc(7'b0000010, 7'b0000000, 7'b0000000, 0, '0, '0);
        check_all("R1 R2 R4 mode1 ownership and grants");

        // same-mode write keeps counts
        wr(4'd0, 8'h05);
        check_all("R8 same mode keeps counts");

        // switch to mode 2: clears, then acquisition while the core owns
        wr(4'd0, 8'h06);
        check_all("R8 mode change clears");
        cyc(7'b1000000, 7'b0010000, 7'b1000000, 0, '0, '0);
        cyc(7'b1000000, 7'b0110000, 7'b0000000, 0, '0, '0);
        cyc(7'b0000000, 7'b0010000, 7'b0000000, 0, '0, '0);
        cyc(7'b0010000, 7'b0010000, 7'b0010000, 0, '0, '0);
        cyc(7'b0010000, 7'b1000000, 7'b0000000, 0, '0, '0);
        cyc(7'b1000000, 7'b0000000, 7'b1000000, 0, '0, '0);
        check_all("R3 R5 mode2 acquisition and ownership");

        // enable low freezes
        wr(4'd0, 8'h02);
        cyc(7'b1000000, 7'b0110000, 7'b1000000, 0, '0, '0);
        cyc(7'b0100000, 7'b0010000, 7'b0100000, 0, '0, '0);
        check_all("R7 disabled freeze");

        // reads leave counts unchanged over quiet cycles
        wr(4'd0, 8'h06);
        idle(3);
        check_all("R11 read no side effect");
        check_all("R11 read repeated");

        // mode 3 and mode 0 count nothing
        wr(4'd0, 8'h07);
        cyc(7'b0000001, 7'b1111110, 7'b0000001, 0, '0, '0);
        cyc(7'b1000000, 7'b0111111, 7'b0000000, 0, '0, '0);
        check_all("R6 mode3 silent");
        wr(4'd0, 8'h04);
        cyc(7'b0010000, 7'b1111111, 7'b0010000, 0, '0, '0);
        check_all("R6 mode0 silent");

        // saturation: DMA0 owns for 260 cycles
        wr(4'd0, 8'h0D);
        for (int k = 0; k < 260; k++) cyc(7'b0000001, '0, '0, 0, '0, '0);
        check_all("R10 saturate with flag");

        // clear counter 0 only, then wrap
        wr(4'd2, 8'h01);
        check_all("R12 masked clear");
        wr(4'd0, 8'h05);
        for (int k = 0; k < 257; k++) cyc(7'b0000001, '0, '0, 0, '0, '0);
        check_all("R9 wrap with flag");

        // write-one-to-clear, and an overflow racing a clear write
        wr(4'd1, 8'h01);
        check_all("R13 flag cleared");
        for (int k = 0; k < 254; k++) cyc(7'b0000001, '0, '0, 0, '0, '0);
        cyc(7'b0000001, '0, '0, 1, 4'd1, 8'h01);
        check_all("R13 set beats clear");
        cyc(7'b0000001, '0, '0, 1, 4'd2, 8'h01);
        check_all("R12 clear beats event");

        // random traffic with occasional register writes
        for (int k = 0; k < 3000; k++) begin
            logic [6:0] o, r, t;
            int x;
            bit we;
            logic [3:0] wa;
            logic [CW-1:0] wd;
            x = int'($urandom % 9);
            o = (x < 7) ? 7'(1 << x) : '0;
            r = 7'($urandom);
            t = 7'($urandom) & o;
            we = ($urandom % 16) == 0;
            wa = '0;
            wd = CW'($urandom);
            case ($urandom % 3)
                0: begin wa = 4'd0; wd[2] = ($urandom % 5) != 0; end
                1: begin wa = 4'd1; end
                default: begin wa = 4'd2; wd = wd & CW'($urandom); end
            endcase
            cyc(o, r, t, we, wa, wd);
            if (k % 25 == 0) check_all("R1 R2 R3 R4 R5 R9 R12 R13 random");
        end
        check_all("R1 R2 R3 random final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule